// File: doc/BRIEF.md
# Bus Cycle Wait State Generator

This block sequences the timing states of one memory or I/O bus cycle and lengthens the cycle with wait states when a slow target needs more time. A cycle always passes through T1 and T2, then spends zero or more clocks in the wait state TW, and finishes with T3. Wait states can only appear between T2 and T3. Either a CPU access or a DMA transfer may raise the cycle-start strobe, and both get the same treatment.

Two sources can ask for a wait state, and the block combines them by OR. The first is an internal down-counter. At the start of each cycle it is loaded from one of two programmed wait counts: one for memory cycles and one for I/O cycles. The second is an external active-low wait pin. A falling-edge register samples this pin during T2 and during every TW. Each low sample holds the cycle in TW for one more state. The block reports the current timing state, a busy flag and a one-clock cycle-done pulse.

Top module: `bus_wait_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in idle on the next rising edge. The state code is 0, `busy_o` is 0, `done_o` is 0 and the internal wait counter is cleared.
- R2: State codes on `tstate_o` are: 0 idle, 1 T1, 2 T2, 3 TW, 4 T3. When `start_i` is high in idle, the next state is T1. T1 lasts exactly one clock and is followed by T2.
- R3: At the clock edge that starts a cycle, the block loads the internal wait count from `io_waits_i` when `is_io_i` is 1 and from `mem_waits_i` when it is 0. Changes to these inputs later in the cycle have no effect. With the wait pin held high, a count of N gives exactly N TW states.
- R4: `wait_n_i` is sampled on the falling clock edge in T2 and in each TW. A low sample causes a TW at the next rising edge.
- R5: The internal and external requests are combined by OR. If the pin is sampled low in the first L wait decisions and the count is N, the cycle has max(N, L) TW states.
- R6: `done_o` is high for exactly one clock: the clock that follows T3.
- R7: After T3 the block returns to idle, unless `start_i` is high during T3. In that case it goes directly to T1 and loads a new count.
- R8: `start_i` is ignored during T1, T2 and TW. It does not change the number or the order of states in the current cycle.
- R9: A low level on `wait_n_i` outside T2 and TW (in idle, T1 or T3) adds no wait state.
- R10: `busy_o` is high in T1, T2, TW and T3 and low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; timing states advance on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Cycle-start strobe from the CPU or DMA requester |
| is_io_i | input | 1 | 1 selects an I/O cycle, 0 selects a memory cycle |
| mem_waits_i | input | CNT_W | Programmed wait count for memory cycles |
| io_waits_i | input | CNT_W | Programmed wait count for I/O cycles |
| wait_n_i | input | 1 | External wait request, active low |
| tstate_o | output | 3 | Current timing state code |
| busy_o | output | 1 | High while a cycle is in progress |
| done_o | output | 1 | One-clock pulse after T3 |

## Verification
The bench sweeps every combination of cycle type, programmed count and the number of low pin samples, and checks the TW count against max(N, L). A design that adds the two sources instead of ORing them would give too many TW states. A design that decrements the counter one step late would also give too many, and one that drops the last sample taken in TW would give too few. The bench changes the programmed counts and the cycle type right after T1 to catch a design that reads them live rather than at the start edge. It also drives the pin low in T1, T3 and idle to catch an ungated sampler. Back-to-back cycles started during T3, and a reset in the middle of a cycle, check that the done pulse appears together with the next T1 and that the counter is not left holding a stale value.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4
    } tstate_e;

    typedef struct packed {
        logic load;
        logic dec;
    } cnt_ctrl_t;

    // States in which the external pin is sampled and a wait may be decided
    function automatic logic in_wait_window(tstate_e s);
        return (s == TS_T2) || (s == TS_TW);
    endfunction

    function automatic logic wants_wait(logic internal_req, logic external_req);
        return internal_req | external_req;
    endfunction

endpackage

// File: rtl/bwg_wait_sampler.sv
module bwg_wait_sampler (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic wait_n_i,
    output logic ext_req
);
    logic smp_q;

    // Falling-edge capture; outside the window the sample reads "no wait"
    always_ff @(negedge clk) begin
        if (rst)
            smp_q <= 1'b1;
        else if (sample_en)
            smp_q <= wait_n_i;
        else
            smp_q <= 1'b1;
    end

    assign ext_req = ~smp_q;

    // R9: a pin level seen outside T2/TW never becomes a request
    p_gated_sample_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_en |-> !ext_req);

endmodule

// File: rtl/bwg_wait_counter.sv
module bwg_wait_counter #(
    parameter int CNT_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  bwg_pkg::cnt_ctrl_t          ctrl,
    input  logic [CNT_W-1:0]            load_val,
    output logic                        int_req
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= ZERO;
        else if (ctrl.load)
            cnt_q <= load_val;
        else if (ctrl.dec && (cnt_q != ZERO))
            cnt_q <= cnt_q - ONE;
    end

    assign int_req = (cnt_q != ZERO);

    // R3: the count is captured at the start edge
    p_load_capture_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl.load |=> (cnt_q == $past(load_val)));

    // R3: no wrap below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.load && cnt_q == ZERO) |=> (cnt_q == ZERO));

    // R1: reset clears the counter
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt_q == ZERO));

endmodule

// File: rtl/bwg_tstate_fsm.sv
module bwg_tstate_fsm (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                int_req,
    input  logic                ext_req,
    output bwg_pkg::tstate_e    state,
    output bwg_pkg::cnt_ctrl_t  ctrl,
    output logic                done_o
);
    import bwg_pkg::*;

    tstate_e st_q, st_d;
    logic    need;
    logic    accept_start;

    assign need         = wants_wait(int_req, ext_req);
    assign accept_start = start_i && ((st_q == TS_IDLE) || (st_q == TS_T3));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: st_d = start_i ? TS_T1 : TS_IDLE;
            TS_T1:   st_d = TS_T2;
            TS_T2,
            TS_TW:   st_d = need ? TS_TW : TS_T3;
            TS_T3:   st_d = start_i ? TS_T1 : TS_IDLE;
            default: st_d = TS_IDLE;
        endcase
    end

    always_comb begin
        ctrl.load = accept_start;
        ctrl.dec  = in_wait_window(st_q) && need;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_IDLE;
            done_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= (st_q == TS_T3);
        end
    end

    assign state = st_q;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (st_q == TS_IDLE && !done_o));

    p_t1_then_t2_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_T1) |=> (st_q == TS_T2));

    p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_IDLE && start_i) |=> (st_q == TS_T1));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wait_window(st_q) && !int_req && !ext_req) |=> (st_q == TS_T3));

    p_ext_extends_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wait_window(st_q) && ext_req) |=> (st_q == TS_TW));

    p_int_extends_r5: assert property (@(posedge clk) disable iff (rst)
        (in_wait_window(st_q) && int_req) |=> (st_q == TS_TW));

    p_done_after_t3_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_T3) |=> done_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_t3_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_T3 && !start_i) |=> (st_q == TS_IDLE));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        in_wait_window(st_q) |=> (st_q == TS_TW || st_q == TS_T3));

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             is_io_i,
    input  logic [CNT_W-1:0] mem_waits_i,
    input  logic [CNT_W-1:0] io_waits_i,
    input  logic             wait_n_i,
    output logic [2:0]       tstate_o,
    output logic             busy_o,
    output logic             done_o
);
    import bwg_pkg::*;

    tstate_e          state;
    cnt_ctrl_t        ctrl;
    logic             int_req;
    logic             ext_req;
    logic [CNT_W-1:0] sel_waits;

    assign sel_waits = is_io_i ? io_waits_i : mem_waits_i;

    bwg_tstate_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .int_req (int_req),
        .ext_req (ext_req),
        .state   (state),
        .ctrl    (ctrl),
        .done_o  (done_o)
    );

    bwg_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .load_val (sel_waits),
        .int_req  (int_req)
    );

    bwg_wait_sampler u_smp (
        .clk       (clk),
        .rst       (rst),
        .sample_en (in_wait_window(state)),
        .wait_n_i  (wait_n_i),
        .ext_req   (ext_req)
    );

    assign tstate_o = state;
    assign busy_o   = (state != TS_IDLE);

    // R10: busy rises only on entry to T1
    p_busy_entry_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (tstate_o == 3'd1));

endmodule

// File: tb/bus_wait_gen_tb_top.sv
module bus_wait_gen_tb_top;
    localparam int CNT_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic is_io_i = 1'b0;
    logic [CNT_W-1:0] mem_waits_i = '0;
    logic [CNT_W-1:0] io_waits_i = '0;
    logic wait_n_i = 1'b1;
    logic [2:0] tstate_o;
    logic busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_wait_gen #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .is_io_i(is_io_i),
        .mem_waits_i(mem_waits_i), .io_waits_i(io_waits_i),
        .wait_n_i(wait_n_i), .tstate_o(tstate_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entered while observing T1 of a cycle started with (io, mw, iw)
    task automatic body(input int io, input int mw, input int iw, input int l_low,
                        input bit noise, input bit hold, input bit chain);
        int n_cnt;
        int e_tw;
        n_cnt = io ? iw : mw;
        e_tw  = (n_cnt > l_low) ? n_cnt : l_low;
        start_i  = hold;
        wait_n_i = noise ? 1'b0 : 1'b1;
        if (!chain) begin
            is_io_i     = ~is_io_i;
            mem_waits_i = ~mem_waits_i;
            io_waits_i  = ~io_waits_i;
        end
        step();
        chk("R2 T2 follows T1", int'(tstate_o), 2);
        chk("R6 done low inside cycle", int'(done_o), 0);
        for (int k = 0; k <= e_tw; k++) begin
            wait_n_i = (k < l_low) ? 1'b0 : 1'b1;
            step();
            if (k < e_tw)
                chk("R5 R3 R4 wait state expected", int'(tstate_o), 3);
            else
                chk("R5 R3 R4 T3 after max(N,L) waits", int'(tstate_o), 4);
            chk("R10 busy in cycle", int'(busy_o), 1);
        end
        start_i  = chain;
        wait_n_i = noise ? 1'b0 : 1'b1;
        if (chain) begin
            is_io_i     = io[0];
            mem_waits_i = mw[CNT_W-1:0];
            io_waits_i  = iw[CNT_W-1:0];
        end
        step();
        chk("R6 done pulse after T3", int'(done_o), 1);
        if (chain) begin
            chk("R7 direct restart to T1", int'(tstate_o), 1);
        end else begin
            chk("R7 back to idle", int'(tstate_o), 0);
            chk("R10 busy low in idle", int'(busy_o), 0);
        end
        start_i = 1'b0;
    endtask

    task automatic launch(input int io, input int mw, input int iw, input int l_low,
                          input bit noise, input bit hold, input bit chain);
        is_io_i     = io[0];
        mem_waits_i = mw[CNT_W-1:0];
        io_waits_i  = iw[CNT_W-1:0];
        start_i     = 1'b1;
        wait_n_i    = noise ? 1'b0 : 1'b1;
        step();
        chk("R2 T1 after start", int'(tstate_o), 1);
        chk("R10 busy on T1", int'(busy_o), 1);
        body(io, mw, iw, l_low, noise, hold, chain);
        if (chain) begin
            body(io, mw, iw, l_low, noise, 1'b0, 1'b0);
        end
        wait_n_i = 1'b1;
        step();
        chk("R6 done single clock", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(); step(); step();
        chk("R1 reset state code", int'(tstate_o), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst = 1'b0;
        step();
        chk("R2 idle without start", int'(tstate_o), 0);

        // Sweep: cycle type x counts x low-sample length; noise checks R9, hold checks R8
        for (int io = 0; io < 2; io++)
            for (int mw = 0; mw < 4; mw++)
                for (int iw = 0; iw < 4; iw++)
                    for (int l_low = 0; l_low < 5; l_low++)
                        launch(io, mw, iw, l_low, l_low[0], (mw == iw), 1'b0);

        // R7 back-to-back cycles started during T3
        for (int mw = 0; mw < 4; mw++)
            for (int l_low = 0; l_low < 4; l_low++)
                launch(0, mw, 3 - mw, l_low, 1'b0, 1'b0, 1'b1);
        launch(1, 0, 2, 1, 1'b1, 1'b1, 1'b1);

        // R1 reset in the middle of a waited cycle
        is_io_i = 1'b0; mem_waits_i = 2'd3; start_i = 1'b1;
        step();
        start_i = 1'b0;
        step();
        step();
        chk("R1 precondition in TW", int'(tstate_o), 3);
        rst = 1'b1;
        step();
        chk("R1 mid-cycle reset state", int'(tstate_o), 0);
        chk("R1 mid-cycle reset busy", int'(busy_o), 0);
        chk("R1 mid-cycle reset done", int'(done_o), 0);
        rst = 1'b0;
        step();
        launch(0, 0, 0, 0, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule